// File: doc/BRIEF.md
# Byte ALU with Selectable Carry Input and Flag Subsets

This block is the arithmetic and logic stage of a small byte-wide processor datapath. Each cycle it picks an A operand and a B operand, applies one of twelve operations and shows the byte result on its output without a register stage. At the next clock edge it updates the subset of status flags that a separate flag command selects. Subtraction and compare have no operation code of their own. They are an add with B complemented and with a chosen carry input. A saved carry kept from the last add lets a sequencer chain byte-wide steps into wider arithmetic. A word-zero flag mode lets such a chain report zero for the whole multi-byte value.

The decoder that drives this block owns the register file, the instruction encoding and any multiply or divide sequencing. This block only needs a command on each cycle. The interrupt-enable flag starts set after reset, and a flag command can only clear it.

Top module: `alu8_flagged`

## Requirements
- R1: Operation code `op_cmd` selects the result as follows. 0 is A + B' + carry-in, where B' is B, complemented when `inv_b` is 1. 1 is A AND B, 2 is A OR B, 3 is A XOR B, 4 is NOT A, 8 is A and 9 is B. The logic operations and pass-B use B without complementing it.
- R2: Codes 5 to 7 and 0xA and 0xB shift A. 5 shifts left with a 0 in bit 0 and carry-out = A[7]. 6 shifts right with a 0 in bit 7. 7 shifts right and copies A[7]. 0xA rotates right. 0xB rotates right with the current carry flag entering bit 7. Codes 6, 7, 0xA and 0xB all give carry-out = A[0].
- R3: `cin_sel` sets the adder carry input: 000 gives 0, 001 gives 1, 010 gives the inverse of the carry flag, 011 gives the saved carry and 100 gives the carry flag. Codes 101 to 111 give 0.
- R4: `a_sel` 00 takes A from `reg_a` and 01 takes it from `imm_byte`. Codes 10 and 11 give A = 0.
- R5: `b_sel` 00 takes B from `reg_b` and 01 gives 0. 10 gives a byte in which every bit equals bit 7 of the A operand chosen in the previous cycle. Code 11 gives 0.
- R6: Flag command 001 updates Z and N. 010 updates Z, C and N. 011 updates Z, C, N and V. Z is set when the result is 0, and N takes result bit 7. C takes the carry-out from the add or shift operations. For codes 1-4, 8 and 9, C keeps its value.
- R7: V is set when the two adder inputs (B after complementing) have the same bit 7 and the sum's bit 7 differs from it. Non-add operations load V as 0. Only flag command 011 changes V.
- R8: Flag command 110 updates C and N as in R6. It sets Z only when the result is 0 and Z was already 1.
- R9: Flag command 100 clears the interrupt-enable flag and changes no other flag. No command sets the interrupt-enable flag again.
- R10: Every add operation (code 0) stores its adder carry-out as the saved carry, whatever the flag command.
- R11: Operation codes 0xC to 0xF give result 0 and leave every flag and the saved carry unchanged.
- R12: Flag commands 000, 101 and 111 leave every flag unchanged.
- R13: A synchronous active-low reset clears Z, C, N, V, the saved carry and the stored A bit 7, and sets interrupt-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_cmd | input | 4 | Operation code |
| inv_b | input | 1 | Complement B before the adder |
| cin_sel | input | 3 | Adder carry-input select |
| a_sel | input | 2 | A operand select |
| b_sel | input | 2 | B operand select |
| flag_cmd | input | 3 | Flag-update command |
| reg_a | input | 8 | Register data for A |
| imm_byte | input | 8 | Immediate byte for A |
| reg_b | input | 8 | Register data for B |
| result | output | 8 | Result (combinational) |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_ie | output | 1 | Interrupt-enable flag |

## Verification
The assertions check on every cycle the flag effects that depend only on the port values. These are Z and N following the result, the word-zero chaining, V staying put under commands that do not own it, the freeze on unused operation and flag codes, and interrupt-enable only falling. Only the bench scenarios can show that each operation's arithmetic is correct. The same holds for the five carry-input sources, the saved carry carried across cycles and the sign-fill byte from the previous cycle's A. The bench compares these against a reference model that tracks every flag.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'h0,
      OP_AND   = 4'h1,
      OP_OR    = 4'h2,
      OP_XOR   = 4'h3,
      OP_NOT   = 4'h4,
      OP_SHL   = 4'h5,
      OP_SHR   = 4'h6,
      OP_ASR   = 4'h7,
      OP_PASSA = 4'h8,
      OP_PASSB = 4'h9,
      OP_ROR   = 4'hA,
      OP_RRC   = 4'hB
   } op_e;

   localparam logic [3:0] OP_LAST_VALID = 4'hB;

   // carry-input sources
   localparam logic [2:0] CIN_ZERO  = 3'b000;
   localparam logic [2:0] CIN_ONE   = 3'b001;
   localparam logic [2:0] CIN_NOTC  = 3'b010;
   localparam logic [2:0] CIN_SAVED = 3'b011;
   localparam logic [2:0] CIN_CFLAG = 3'b100;

   // flag-update commands
   localparam logic [2:0] FL_NONE  = 3'b000;
   localparam logic [2:0] FL_ZN    = 3'b001;
   localparam logic [2:0] FL_ZCN   = 3'b010;
   localparam logic [2:0] FL_ZCNV  = 3'b011;
   localparam logic [2:0] FL_IECLR = 3'b100;
   localparam logic [2:0] FL_WZCN  = 3'b110;

   // operand sources
   localparam logic [1:0] ASEL_REG  = 2'b00;
   localparam logic [1:0] ASEL_IMM  = 2'b01;
   localparam logic [1:0] BSEL_REG  = 2'b00;
   localparam logic [1:0] BSEL_ZERO = 2'b01;
   localparam logic [1:0] BSEL_SIGN = 2'b10;

endpackage

// File: rtl/alu8_opsel.sv
module alu8_opsel
   import alu8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   a_sel,
   input  logic [1:0]   b_sel,
   input  logic         inv_b,
   input  logic [W-1:0] reg_a,
   input  logic [W-1:0] imm_byte,
   input  logic [W-1:0] reg_b,
   output logic [W-1:0] a_op,
   output logic [W-1:0] b_raw,
   output logic [W-1:0] b_add
);

   localparam int MSB = W - 1;

   logic prev_a_msb;

   always_comb begin
      case (a_sel)
         ASEL_REG: a_op = reg_a;
         ASEL_IMM: a_op = imm_byte;
         default:  a_op = '0;
      endcase
   end

   always_comb begin
      case (b_sel)
         BSEL_REG:  b_raw = reg_b;
         BSEL_ZERO: b_raw = '0;
         BSEL_SIGN: b_raw = {W{prev_a_msb}};
         default:   b_raw = '0;
      endcase
   end

   assign b_add = inv_b ? ~b_raw : b_raw;

   // sign of the A operand seen in the previous cycle, for sign extension
   always_ff @(posedge clk) begin
      if (!rst_n) prev_a_msb <= 1'b0;
      else        prev_a_msb <= a_op[MSB];
   end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
   import alu8_pkg::*;
#(
   parameter int W      = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a_op,
   input  logic [W-1:0] b_raw,
   input  logic [W-1:0] b_add,
   input  logic [3:0]   op,
   input  logic [2:0]   cin_sel,
   input  logic         c_flag,
   input  logic         saved_c,
   output logic [W-1:0] result,
   output logic         cout,
   output logic         c_touch,
   output logic         ovf,
   output logic         op_valid,
   output logic         add_op
);

   localparam int MSB = W - 1;

   logic         cin;
   logic [W-1:0] sum;
   logic         sum_co;

   always_comb begin
      case (cin_sel)
         CIN_ZERO:  cin = 1'b0;
         CIN_ONE:   cin = 1'b1;
         CIN_NOTC:  cin = ~c_flag;
         CIN_SAVED: cin = saved_c;
         CIN_CFLAG: cin = c_flag;
         default:   cin = 1'b0;
      endcase
   end

   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] chain;
         assign chain[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]     = a_op[i] ^ b_add[i] ^ chain[i];
            assign chain[i+1] = (a_op[i] & b_add[i]) | (chain[i] & (a_op[i] ^ b_add[i]));
         end
         assign sum_co = chain[W];
      end else begin : g_behav
         logic [W:0] wide;
         assign wide   = {1'b0, a_op} + {1'b0, b_add} + {{W{1'b0}}, cin};
         assign sum    = wide[W-1:0];
         assign sum_co = wide[W];
      end
   endgenerate

   assign op_valid = (op <= OP_LAST_VALID);
   assign add_op   = (op == OP_ADD);

   always_comb begin
      result  = '0;
      cout    = 1'b0;
      c_touch = 1'b0;
      ovf     = 1'b0;
      case (op)
         OP_ADD: begin
            result  = sum;
            cout    = sum_co;
            c_touch = 1'b1;
            ovf     = (a_op[MSB] == b_add[MSB]) && (sum[MSB] != a_op[MSB]);
         end
         OP_AND:   result = a_op & b_raw;
         OP_OR:    result = a_op | b_raw;
         OP_XOR:   result = a_op ^ b_raw;
         OP_NOT:   result = ~a_op;
         OP_SHL: begin
            result  = {a_op[MSB-1:0], 1'b0};
            cout    = a_op[MSB];
            c_touch = 1'b1;
         end
         OP_SHR: begin
            result  = {1'b0, a_op[MSB:1]};
            cout    = a_op[0];
            c_touch = 1'b1;
         end
         OP_ASR: begin
            result  = {a_op[MSB], a_op[MSB:1]};
            cout    = a_op[0];
            c_touch = 1'b1;
         end
         OP_PASSA: result = a_op;
         OP_PASSB: result = b_raw;
         OP_ROR: begin
            result  = {a_op[0], a_op[MSB:1]};
            cout    = a_op[0];
            c_touch = 1'b1;
         end
         OP_RRC: begin
            result  = {c_flag, a_op[MSB:1]};
            cout    = a_op[0];
            c_touch = 1'b1;
         end
         default: result = '0;
      endcase
   end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
   import alu8_pkg::*;
#(
   parameter int W        = 8,
   parameter bit IE_RESET = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [2:0]   flag_cmd,
   input  logic         op_valid,
   input  logic         add_op,
   input  logic [W-1:0] result,
   input  logic         cout,
   input  logic         c_touch,
   input  logic         ovf,
   output logic         z_q,
   output logic         c_q,
   output logic         n_q,
   output logic         v_q,
   output logic         ie_q,
   output logic         saved_c_q
);

   localparam int MSB = W - 1;

   logic byte_zero;
   logic c_next;

   assign byte_zero = (result == '0);
   assign c_next    = c_touch ? cout : c_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         z_q       <= 1'b0;
         c_q       <= 1'b0;
         n_q       <= 1'b0;
         v_q       <= 1'b0;
         ie_q      <= IE_RESET;
         saved_c_q <= 1'b0;
      end else if (op_valid) begin
         if (add_op) saved_c_q <= cout;
         case (flag_cmd)
            FL_ZN: begin
               z_q <= byte_zero;
               n_q <= result[MSB];
            end
            FL_ZCN: begin
               z_q <= byte_zero;
               c_q <= c_next;
               n_q <= result[MSB];
            end
            FL_ZCNV: begin
               z_q <= byte_zero;
               c_q <= c_next;
               n_q <= result[MSB];
               v_q <= ovf;
            end
            FL_WZCN: begin
               z_q <= byte_zero & z_q;
               c_q <= c_next;
               n_q <= result[MSB];
            end
            FL_IECLR: ie_q <= 1'b0;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/alu8_flagged.sv
module alu8_flagged
   import alu8_pkg::*;
#(
   parameter int W        = 8,
   parameter bit RIPPLE   = 1'b1,
   parameter bit IE_RESET = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [3:0]   op_cmd,
   input  logic         inv_b,
   input  logic [2:0]   cin_sel,
   input  logic [1:0]   a_sel,
   input  logic [1:0]   b_sel,
   input  logic [2:0]   flag_cmd,
   input  logic [W-1:0] reg_a,
   input  logic [W-1:0] imm_byte,
   input  logic [W-1:0] reg_b,
   output logic [W-1:0] result,
   output logic         flag_z,
   output logic         flag_c,
   output logic         flag_n,
   output logic         flag_v,
   output logic         flag_ie
);

   generate
      if (W < 2) begin : g_bad_width
         $error("alu8_flagged: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] a_op, b_raw, b_add;
   logic         cout, c_touch, ovf, op_valid, add_op, saved_c;

   alu8_opsel #(.W(W)) u_opsel (
      .clk      (clk),
      .rst_n    (rst_n),
      .a_sel    (a_sel),
      .b_sel    (b_sel),
      .inv_b    (inv_b),
      .reg_a    (reg_a),
      .imm_byte (imm_byte),
      .reg_b    (reg_b),
      .a_op     (a_op),
      .b_raw    (b_raw),
      .b_add    (b_add)
   );

   alu8_core #(.W(W), .RIPPLE(RIPPLE)) u_core (
      .a_op     (a_op),
      .b_raw    (b_raw),
      .b_add    (b_add),
      .op       (op_cmd),
      .cin_sel  (cin_sel),
      .c_flag   (flag_c),
      .saved_c  (saved_c),
      .result   (result),
      .cout     (cout),
      .c_touch  (c_touch),
      .ovf      (ovf),
      .op_valid (op_valid),
      .add_op   (add_op)
   );

   alu8_flags #(.W(W), .IE_RESET(IE_RESET)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .flag_cmd  (flag_cmd),
      .op_valid  (op_valid),
      .add_op    (add_op),
      .result    (result),
      .cout      (cout),
      .c_touch   (c_touch),
      .ovf       (ovf),
      .z_q       (flag_z),
      .c_q       (flag_c),
      .n_q       (flag_n),
      .v_q       (flag_v),
      .ie_q      (flag_ie),
      .saved_c_q (saved_c)
   );

endmodule

// File: rtl/alu8_flagged_chk.sv
module alu8_flagged_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [3:0]   op_cmd,
   input logic [2:0]   flag_cmd,
   input logic [W-1:0] result,
   input logic         flag_z,
   input logic         flag_c,
   input logic         flag_n,
   input logic         flag_v,
   input logic         flag_ie
);

   logic known_op;
   assign known_op = (op_cmd < 4'd12);

   // R6: zero and negative follow the result under the plain update commands
   p_z_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (known_op && (flag_cmd == 3'b001 || flag_cmd == 3'b010 || flag_cmd == 3'b011))
      |=> (flag_z == ($past(result) == '0)));

   p_n_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (known_op && (flag_cmd == 3'b001 || flag_cmd == 3'b010 ||
                    flag_cmd == 3'b011 || flag_cmd == 3'b110))
      |=> (flag_n == $past(result[W-1])));

   // R7: only the full command may touch overflow
   p_v_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_cmd == 3'b001 || flag_cmd == 3'b010 || flag_cmd == 3'b110)
      |=> $stable(flag_v));

   // R8: word zero chains with the previous zero flag
   p_word_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (known_op && flag_cmd == 3'b110)
      |=> (flag_z == (($past(result) == '0) && $past(flag_z))));

   // R9: interrupt enable is cleared by its command and never rises
   p_ie_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (known_op && flag_cmd == 3'b100) |=> !flag_ie);

   p_ie_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_ie |=> !flag_ie);

   // R11: unused operations produce zero and freeze the flags
   p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !known_op |-> (result == '0));

   p_unused_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !known_op |=> $stable({flag_z, flag_c, flag_n, flag_v, flag_ie}));

   // R12: no-update flag commands freeze the flags
   p_no_update_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_cmd == 3'b000 || flag_cmd == 3'b101 || flag_cmd == 3'b111)
      |=> $stable({flag_z, flag_c, flag_n, flag_v, flag_ie}));

endmodule

bind alu8_flagged alu8_flagged_chk #(.W(W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_cmd   (op_cmd),
   .flag_cmd (flag_cmd),
   .result   (result),
   .flag_z   (flag_z),
   .flag_c   (flag_c),
   .flag_n   (flag_n),
   .flag_v   (flag_v),
   .flag_ie  (flag_ie)
);

// File: tb/alu8_flagged_test.sv
module alu8_flagged_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_cmd = '0;
   logic       inv_b = 1'b0;
   logic [2:0] cin_sel = '0;
   logic [1:0] a_sel = '0;
   logic [1:0] b_sel = '0;
   logic [2:0] flag_cmd = '0;
   logic [7:0] reg_a = '0, imm_byte = '0, reg_b = '0;
   logic [7:0] result;
   logic       flag_z, flag_c, flag_n, flag_v, flag_ie;

   int n_checks = 0;
   int n_fail   = 0;

   // reference state
   logic mz, mc, mn, mv, mie, msc, mmsb;

   always #5 clk = ~clk;

   alu8_flagged uut (
      .clk(clk), .rst_n(rst_n), .op_cmd(op_cmd), .inv_b(inv_b), .cin_sel(cin_sel),
      .a_sel(a_sel), .b_sel(b_sel), .flag_cmd(flag_cmd), .reg_a(reg_a),
      .imm_byte(imm_byte), .reg_b(reg_b), .result(result), .flag_z(flag_z),
      .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v), .flag_ie(flag_ie)
   );

   // {op, inv, cin, asel, bsel, fcmd, reg_a, imm, reg_b}
   localparam int NV = 40;
   localparam logic [38:0] VEC [NV] = '{
      {4'h0,1'b0,3'b000,2'b00,2'b00,3'b011,8'h3C,8'h00,8'h05}, // R1 add
      {4'h0,1'b0,3'b000,2'b00,2'b00,3'b011,8'h7F,8'h00,8'h01}, // R7 overflow
      {4'h0,1'b0,3'b000,2'b00,2'b00,3'b011,8'hFF,8'h00,8'h01}, // R6 carry+zero
      {4'h0,1'b0,3'b100,2'b00,2'b00,3'b011,8'h10,8'h00,8'h20}, // R3 carry flag in
      {4'h0,1'b1,3'b001,2'b00,2'b00,3'b011,8'h50,8'h00,8'h30}, // R3 subtract
      {4'h0,1'b1,3'b001,2'b00,2'b00,3'b011,8'h30,8'h00,8'h50}, // R3 borrow
      {4'h0,1'b1,3'b010,2'b00,2'b00,3'b011,8'h80,8'h00,8'h01}, // R3 inverted carry, R7
      {4'h0,1'b1,3'b001,2'b00,2'b00,3'b010,8'h44,8'h00,8'h44}, // R6 compare equal
      {4'h0,1'b0,3'b000,2'b00,2'b00,3'b000,8'hF0,8'h00,8'h20}, // R10 saved carry set
      {4'h0,1'b0,3'b011,2'b00,2'b00,3'b001,8'h00,8'h00,8'h00}, // R10 saved carry used
      {4'h0,1'b0,3'b011,2'b00,2'b00,3'b001,8'h00,8'h00,8'h00}, // R10 saved carry now 0
      {4'h0,1'b0,3'b000,2'b01,2'b00,3'b011,8'h99,8'h11,8'h22}, // R4 immediate
      {4'h0,1'b0,3'b000,2'b10,2'b00,3'b011,8'h99,8'h11,8'h22}, // R4 unused code
      {4'h0,1'b0,3'b000,2'b11,2'b00,3'b011,8'h99,8'h11,8'h22}, // R4 unused code
      {4'h0,1'b0,3'b001,2'b00,2'b01,3'b011,8'h09,8'h00,8'h77}, // R5 zero B
      {4'h8,1'b0,3'b000,2'b00,2'b00,3'b000,8'h85,8'h00,8'h00}, // R1 pass A, negative
      {4'h0,1'b0,3'b000,2'b00,2'b10,3'b011,8'h12,8'h00,8'h00}, // R5 sign fill ones
      {4'h0,1'b0,3'b000,2'b00,2'b10,3'b011,8'h12,8'h00,8'h00}, // R5 sign fill zeros
      {4'h0,1'b0,3'b000,2'b00,2'b11,3'b011,8'h12,8'h00,8'h66}, // R5 unused code
      {4'h1,1'b1,3'b000,2'b00,2'b00,3'b001,8'hF0,8'h00,8'h3C}, // R1 and, no inversion
      {4'h2,1'b0,3'b000,2'b00,2'b00,3'b001,8'hF0,8'h00,8'h0C}, // R1 or
      {4'h3,1'b0,3'b000,2'b00,2'b00,3'b001,8'hFF,8'h00,8'hFF}, // R1 xor zero
      {4'h4,1'b0,3'b000,2'b00,2'b00,3'b010,8'h0F,8'h00,8'h00}, // R1 not, carry kept
      {4'h5,1'b0,3'b000,2'b00,2'b00,3'b010,8'h81,8'h00,8'h00}, // R2 shift left
      {4'h6,1'b0,3'b000,2'b00,2'b00,3'b010,8'h03,8'h00,8'h00}, // R2 shift right
      {4'h7,1'b0,3'b000,2'b00,2'b00,3'b010,8'h82,8'h00,8'h00}, // R2 arith right
      {4'h5,1'b0,3'b000,2'b00,2'b00,3'b010,8'h80,8'h00,8'h00}, // R2 set carry
      {4'hB,1'b0,3'b000,2'b00,2'b00,3'b010,8'h02,8'h00,8'h00}, // R2 rotate through carry
      {4'hB,1'b0,3'b000,2'b00,2'b00,3'b010,8'h02,8'h00,8'h00}, // R2 rotate through carry
      {4'hA,1'b0,3'b000,2'b00,2'b00,3'b010,8'h01,8'h00,8'h00}, // R2 rotate right
      {4'h8,1'b0,3'b000,2'b00,2'b00,3'b011,8'h40,8'h00,8'h00}, // R7 V cleared
      {4'h9,1'b1,3'b000,2'b00,2'b00,3'b010,8'h00,8'h00,8'hA5}, // R1 pass B
      {4'hD,1'b0,3'b001,2'b00,2'b00,3'b011,8'h55,8'h00,8'h55}, // R11 unused op
      {4'hE,1'b0,3'b000,2'b00,2'b00,3'b100,8'h00,8'h00,8'h00}, // R11 keeps IE
      {4'h0,1'b0,3'b000,2'b00,2'b00,3'b101,8'h00,8'h00,8'h00}, // R12 code 101
      {4'h0,1'b0,3'b000,2'b00,2'b00,3'b111,8'h01,8'h00,8'h00}, // R12 code 111
      {4'h0,1'b0,3'b101,2'b00,2'b00,3'b001,8'hFF,8'h00,8'h00}, // R3 cin 101 is zero
      {4'h8,1'b0,3'b000,2'b00,2'b00,3'b110,8'h00,8'h00,8'h00}, // R8 word zero kept
      {4'h8,1'b0,3'b000,2'b00,2'b00,3'b110,8'h01,8'h00,8'h00}, // R8 word non-zero
      {4'h8,1'b0,3'b000,2'b00,2'b00,3'b100,8'h00,8'h00,8'h00}  // R9 clear IE
   };

   function automatic string op_req(input logic [3:0] op);
      if (op >= 4'hC) return "R11";
      if (op == 4'h5 || op == 4'h6 || op == 4'h7 || op == 4'hA || op == 4'hB) return "R2";
      return "R1";
   endfunction

   task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      mz = 0; mc = 0; mn = 0; mv = 0; mie = 1; msc = 0; mmsb = 0;
   endtask

   task automatic run_vec(input logic [38:0] v, input string freq);
      logic [7:0] a, b, bx, res;
      logic [8:0] s;
      logic cin, co, touch, ov;
      {op_cmd, inv_b, cin_sel, a_sel, b_sel, flag_cmd, reg_a, imm_byte, reg_b} = v;
      #2;
      a  = (a_sel == 2'b00) ? reg_a : (a_sel == 2'b01) ? imm_byte : 8'h00;
      b  = (b_sel == 2'b00) ? reg_b : (b_sel == 2'b10) ? {8{mmsb}} : 8'h00;
      bx = inv_b ? ~b : b;
      case (cin_sel)
         3'b001: cin = 1'b1;
         3'b010: cin = ~mc;
         3'b011: cin = msc;
         3'b100: cin = mc;
         default: cin = 1'b0;
      endcase
      s = {1'b0, a} + {1'b0, bx} + {8'h00, cin};
      co = 0; touch = 0; ov = 0; res = 8'h00;
      case (op_cmd)
         4'h0: begin res = s[7:0]; co = s[8]; touch = 1;
                     ov = (a[7] == bx[7]) && (res[7] != a[7]); end
         4'h1: res = a & b;
         4'h2: res = a | b;
         4'h3: res = a ^ b;
         4'h4: res = ~a;
         4'h5: begin res = {a[6:0], 1'b0}; co = a[7]; touch = 1; end
         4'h6: begin res = {1'b0, a[7:1]}; co = a[0]; touch = 1; end
         4'h7: begin res = {a[7], a[7:1]}; co = a[0]; touch = 1; end
         4'h8: res = a;
         4'h9: res = b;
         4'hA: begin res = {a[0], a[7:1]}; co = a[0]; touch = 1; end
         4'hB: begin res = {mc, a[7:1]}; co = a[0]; touch = 1; end
         default: res = 8'h00;
      endcase
      check_val(op_req(op_cmd), {24'h0, result}, {24'h0, res});
      @(posedge clk);
      #2;
      if (op_cmd < 4'hC) begin
         if (op_cmd == 4'h0) msc = co;
         case (flag_cmd)
            3'b001: begin mz = (res == 0); mn = res[7]; end
            3'b010: begin mz = (res == 0); mn = res[7]; if (touch) mc = co; end
            3'b011: begin mz = (res == 0); mn = res[7]; if (touch) mc = co; mv = ov; end
            3'b110: begin mz = (res == 0) && mz; mn = res[7]; if (touch) mc = co; end
            3'b100: mie = 1'b0;
            default: ;
         endcase
      end
      mmsb = a[7];
      check_val(freq, {27'h0, flag_z, flag_c, flag_n, flag_v, flag_ie},
                {27'h0, mz, mc, mn, mv, mie});
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(posedge clk);
      @(posedge clk);
      #2;
      rst_n = 1'b1;
      model_reset();
      // R13: flags after reset
      check_val("R13", {27'h0, flag_z, flag_c, flag_n, flag_v, flag_ie}, 32'h1);
      // R13: saved carry and stored sign are clear
      run_vec({4'h0,1'b0,3'b011,2'b00,2'b10,3'b000,8'h21,8'h00,8'h00}, "R13");
   endtask

   initial begin : watchdog
      #1_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      model_reset();
      @(posedge clk);
      #2;
      do_reset();
      for (int i = 0; i < NV; i++) begin
         string fr;
         logic [2:0] fc;
         fc = VEC[i][24:22];
         fr = (fc == 3'b110) ? "R8" : (fc == 3'b100) ? "R9" :
              (fc == 3'b000 || fc == 3'b101 || fc == 3'b111) ? "R12" : "R6";
         run_vec(VEC[i], fr);
      end
      // R9: IE stays cleared under later commands
      run_vec({4'h0,1'b0,3'b000,2'b00,2'b00,3'b011,8'h01,8'h00,8'h01}, "R9");
      // R8: chained word zero over two zero bytes
      run_vec({4'h0,1'b0,3'b000,2'b00,2'b00,3'b001,8'h00,8'h00,8'h00}, "R6");
      run_vec({4'h8,1'b0,3'b000,2'b00,2'b00,3'b110,8'h00,8'h00,8'h00}, "R8");
      run_vec({4'h8,1'b0,3'b000,2'b00,2'b00,3'b110,8'h80,8'h00,8'h00}, "R8");
      // R10: add with flag cmd none still updates saved carry
      run_vec({4'h0,1'b0,3'b001,2'b00,2'b00,3'b000,8'hFF,8'h00,8'h00}, "R10");
      run_vec({4'h0,1'b0,3'b011,2'b00,2'b00,3'b001,8'h10,8'h00,8'h10}, "R10");
      // R11: unused op does not change saved carry
      run_vec({4'hF,1'b0,3'b000,2'b00,2'b00,3'b011,8'hFF,8'h00,8'h01}, "R11");
      run_vec({4'h0,1'b0,3'b011,2'b00,2'b00,3'b001,8'h00,8'h00,8'h00}, "R11");
      // R13: reset in the middle of a run restores IE and clears state
      run_vec({4'h5,1'b0,3'b000,2'b00,2'b00,3'b011,8'hC0,8'h00,8'h00}, "R2");
      do_reset();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule